// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block turns single-word read and write requests from a shock-buffer controller into the strobe, address and data waveforms of a 4-bit-wide asynchronous DRAM. Every edge is placed on a whole cycle of one system clock, and the spacing of the edges is fixed. The block accepts a request only while it is idle. It then drives the row address and lowers RAS, switches the bus to the column address and lowers CAS. On a write it drives the data nibble with WE low. On a read it captures the nibble the memory returns. A one-cycle done pulse ends each operation.

A linear word address is folded onto the 11-pin multiplexed bus in one of two ways. A select bit chooses between a 4M-word part, which takes an 11-bit row and an 11-bit column, and a 1M-word part, which takes a 10-bit row and a 10-bit column with the top pin held low. A separate command starts a burst of RAS-only refresh cycles, used to bring a freshly powered memory into service. During the burst CAS stays high and the row walks through the first rows of the array.

Top module: `dram_page_seq`

## Requirements
- R1: While `rst` is high and in the first cycles after it, `ras_n`, `cas_n` and `we_n` are 1, `dq_oe`, `dq_out`, `mem_addr`, `busy`, `done` and `rd_nib` are 0.
- R2: A request is taken at a rising edge while idle; the following cycle is step 0. RAS is low in steps 1 to 4 (exactly 4 cycles) and is high for at least 2 cycles before each falling edge.
- R3: CAS is low in steps 3 and 4, so it falls 2 cycles after RAS falls and stays low for 2 cycles. Between accesses it is high for at least 4 cycles.
- R4: `mem_addr` carries the row in steps 0 and 1, which is one cycle before and one cycle after RAS falls. It carries the column in steps 2 to 4, which is one cycle before and two cycles after CAS falls. It is 0 when no access is in progress.
- R5: On a write (`req_write`=1), `we_n` is 0 and `dq_oe` is 1 in steps 0 to 4. That is 5 cycles, starting 3 cycles before CAS falls. `dq_out` carries the write nibble in the same steps and is 0 in all other cycles. On a read, `we_n` stays 1 and `dq_oe` stays 0.
- R6: On a read, `dq_in` is captured into `rd_nib` at the rising edge that ends step 4, which is the edge at which CAS rises. `done` is 1 for the single following cycle (step 5), and `busy` is 0 in that cycle.
- R7: With `big_mem`=1, the row is `req_addr[21:11]` and the column is `req_addr[10:0]`.
- R8: With `big_mem`=0, the row is `req_addr[19:10]` and the column is `req_addr[9:0]`. Both are placed on `mem_addr[9:0]`, `mem_addr[10]` is 0, and `req_addr[21:20]` have no effect.
- R9: `refresh_go` starts 8 RAS-only cycles, each 6 cycles long. RAS is low in steps 1 to 4, and the row (the cycle index 0 to 7) is on `mem_addr` in steps 0 to 4 and is 0 in step 5. CAS and WE stay high. `done` is 1 in the cycle after the eighth RAS rise.
- R10: `req` and `refresh_go` have no effect while `busy` is 1, and `busy` is 1 in every cycle of an operation except the done cycle.
- R11: When `refresh_go` and `req` are both high at an idle edge, the refresh burst runs and the request is discarded.
- R12: A request presented during the done cycle is taken at the edge that ends it. RAS then falls again after exactly 2 high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Linear word address |
| req_wnib | input | 4 | Nibble to write |
| big_mem | input | 1 | 1 = 4M-word part, 0 = 1M-word part |
| refresh_go | input | 1 | Start a RAS-only refresh burst |
| dq_in | input | 4 | Data returned by the DRAM |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mem_addr | output | 11 | Multiplexed row/column address |
| dq_out | output | 4 | Write data toward the DRAM |
| dq_oe | output | 1 | Drive enable for the data pins |
| rd_nib | output | 4 | Captured read nibble |
| done | output | 1 | One-cycle end-of-operation pulse |
| busy | output | 1 | Operation in progress; requests ignored |

## Verification
All pin values are registered, so the waveform of step k appears in the k-th cycle after the accepting edge. The read nibble is due at the edge that ends step 4, and done appears one cycle later. A refresh burst lasts 48 cycles from acceptance, with done in the last of them. The bench presents each stimulus on a falling edge and compares every output at the falling edge of each cycle from step 0 to the done cycle. It drives a wrong nibble on `dq_in` in every cycle except step 4, so capture at any other edge is visible. It sweeps both memory sizes, both directions and sixteen address patterns. It also probes requests raised mid-access, a request raised in the done cycle and a request raised together with a refresh.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_RD   = 2'd1,
    M_WR   = 2'd2,
    M_REF  = 2'd3
  } seq_mode_e;

  localparam int STEP_W = 3;

  // step positions inside one RAS cycle
  localparam logic [STEP_W-1:0] RAS_ON_FIRST = 3'd1;
  localparam logic [STEP_W-1:0] RAS_ON_LAST  = 3'd4;
  localparam logic [STEP_W-1:0] COL_FIRST    = 3'd2;
  localparam logic [STEP_W-1:0] CAS_ON_FIRST = 3'd3;
  localparam logic [STEP_W-1:0] ACC_LAST     = 3'd4;
  localparam logic [STEP_W-1:0] REF_LAST     = 3'd5;

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int PINS = 11
) (
  input  logic [2*PINS-1:0] word,
  input  logic              big,
  output logic [PINS-1:0]   row,
  output logic [PINS-1:0]   col
);
  localparam int SP = PINS - 1;

  always_comb begin
    if (big) begin
      row = word[2*PINS-1:PINS];
      col = word[PINS-1:0];
    end else begin
      row = {1'b0, word[2*SP-1:SP]};
      col = {1'b0, word[SP-1:0]};
    end
  end
endmodule

// File: rtl/dram_step_ctrl.sv
module dram_step_ctrl
  import dram_seq_pkg::*;
#(
  parameter int REF_BURST = 8,
  parameter int REP_W     = (REF_BURST > 1) ? $clog2(REF_BURST) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              is_write,
  input  logic              ref_go,
  output seq_mode_e         mode,
  output logic [STEP_W-1:0] step,
  output seq_mode_e         nxt_mode,
  output logic [STEP_W-1:0] nxt_step,
  output logic [REP_W-1:0]  nxt_rep,
  output logic              take_acc,
  output logic              finish
);
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(REF_BURST - 1);

  logic [REP_W-1:0] rep;

  always_comb begin
    nxt_mode = mode;
    nxt_step = step;
    nxt_rep  = rep;
    take_acc = 1'b0;
    finish   = 1'b0;
    unique case (mode)
      M_IDLE: begin
        nxt_step = '0;
        nxt_rep  = '0;
        if (ref_go) begin
          nxt_mode = M_REF;
        end else if (req) begin
          nxt_mode = is_write ? M_WR : M_RD;
          take_acc = 1'b1;
        end
      end
      M_RD, M_WR: begin
        if (step == ACC_LAST) begin
          nxt_mode = M_IDLE;
          nxt_step = '0;
          finish   = 1'b1;
        end else begin
          nxt_step = step + 1'b1;
        end
      end
      M_REF: begin
        if (step == ACC_LAST && rep == LAST_REP) begin
          nxt_mode = M_IDLE;
          nxt_step = '0;
          nxt_rep  = '0;
          finish   = 1'b1;
        end else if (step == REF_LAST) begin
          nxt_step = '0;
          nxt_rep  = rep + 1'b1;
        end else begin
          nxt_step = step + 1'b1;
        end
      end
      default: nxt_mode = M_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= M_IDLE;
      step <= '0;
      rep  <= '0;
    end else begin
      mode <= nxt_mode;
      step <= nxt_step;
      rep  <= nxt_rep;
    end
  end
endmodule

// File: rtl/dram_pin_gen.sv
module dram_pin_gen
  import dram_seq_pkg::*;
#(
  parameter int PINS  = 11,
  parameter int NIB_W = 4,
  parameter int REP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_mode_e         mode,
  input  logic [STEP_W-1:0] step,
  input  seq_mode_e         nxt_mode,
  input  logic [STEP_W-1:0] nxt_step,
  input  logic [REP_W-1:0]  nxt_rep,
  input  logic              take_acc,
  input  logic              finish,
  input  logic [PINS-1:0]   row_in,
  input  logic [PINS-1:0]   col_in,
  input  logic [NIB_W-1:0]  wnib_in,
  input  logic [NIB_W-1:0]  dq_in,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [PINS-1:0]   mem_addr,
  output logic [NIB_W-1:0]  dq_out,
  output logic              dq_oe,
  output logic [NIB_W-1:0]  rd_nib,
  output logic              done,
  output logic              busy
);
  logic [PINS-1:0]  row_q, col_q, row_use, col_use;
  logic [NIB_W-1:0] wnib_q, wnib_use;
  logic             p_ras, p_cas, p_we, p_oe, ras_window;
  logic [PINS-1:0]  p_addr;
  logic [NIB_W-1:0] p_dq;

  always_comb begin
    row_use    = take_acc ? row_in  : row_q;
    col_use    = take_acc ? col_in  : col_q;
    wnib_use   = take_acc ? wnib_in : wnib_q;
    ras_window = (nxt_step >= RAS_ON_FIRST) && (nxt_step <= RAS_ON_LAST);
    p_ras  = 1'b1;
    p_cas  = 1'b1;
    p_we   = 1'b1;
    p_oe   = 1'b0;
    p_addr = '0;
    p_dq   = '0;
    unique case (nxt_mode)
      M_RD, M_WR: begin
        p_ras  = !ras_window;
        p_cas  = !(nxt_step >= CAS_ON_FIRST);
        p_addr = (nxt_step >= COL_FIRST) ? col_use : row_use;
        if (nxt_mode == M_WR) begin
          p_we = 1'b0;
          p_oe = 1'b1;
          p_dq = wnib_use;
        end
      end
      M_REF: begin
        p_ras = !ras_window;
        if (nxt_step <= RAS_ON_LAST) p_addr = PINS'(nxt_rep);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      mem_addr <= '0;
      dq_out   <= '0;
      rd_nib   <= '0;
      done     <= 1'b0;
      busy     <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      wnib_q   <= '0;
    end else begin
      ras_n    <= p_ras;
      cas_n    <= p_cas;
      we_n     <= p_we;
      dq_oe    <= p_oe;
      mem_addr <= p_addr;
      dq_out   <= p_dq;
      done     <= finish;
      busy     <= (nxt_mode != M_IDLE);
      if (take_acc) begin
        row_q  <= row_in;
        col_q  <= col_in;
        wnib_q <= wnib_in;
      end
      if (mode == M_RD && step == ACC_LAST) rd_nib <= dq_in;
    end
  end
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_PINS = 11,
  parameter int NIB_W     = 4,
  parameter int REF_BURST = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req,
  input  logic                   req_write,
  input  logic [2*ADDR_PINS-1:0] req_addr,
  input  logic [NIB_W-1:0]       req_wnib,
  input  logic                   big_mem,
  input  logic                   refresh_go,
  input  logic [NIB_W-1:0]       dq_in,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic [ADDR_PINS-1:0]   mem_addr,
  output logic [NIB_W-1:0]       dq_out,
  output logic                   dq_oe,
  output logic [NIB_W-1:0]       rd_nib,
  output logic                   done,
  output logic                   busy
);
  localparam int REP_W = (REF_BURST > 1) ? $clog2(REF_BURST) : 1;

  seq_mode_e             mode, nxt_mode;
  logic [STEP_W-1:0]     step, nxt_step;
  logic [REP_W-1:0]      nxt_rep;
  logic                  take_acc, finish;
  logic [ADDR_PINS-1:0]  row_in, col_in;

  dram_addr_split #(.PINS(ADDR_PINS)) u_split (
    .word (req_addr),
    .big  (big_mem),
    .row  (row_in),
    .col  (col_in)
  );

  dram_step_ctrl #(.REF_BURST(REF_BURST), .REP_W(REP_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .is_write (req_write),
    .ref_go   (refresh_go),
    .mode     (mode),
    .step     (step),
    .nxt_mode (nxt_mode),
    .nxt_step (nxt_step),
    .nxt_rep  (nxt_rep),
    .take_acc (take_acc),
    .finish   (finish)
  );

  dram_pin_gen #(.PINS(ADDR_PINS), .NIB_W(NIB_W), .REP_W(REP_W)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .step     (step),
    .nxt_mode (nxt_mode),
    .nxt_step (nxt_step),
    .nxt_rep  (nxt_rep),
    .take_acc (take_acc),
    .finish   (finish),
    .row_in   (row_in),
    .col_in   (col_in),
    .wnib_in  (req_wnib),
    .dq_in    (dq_in),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .mem_addr (mem_addr),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .rd_nib   (rd_nib),
    .done     (done),
    .busy     (busy)
  );
endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk #(
  parameter int ADDR_PINS = 11
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [ADDR_PINS-1:0] mem_addr,
  input logic                 done,
  input logic                 busy
);
  // R2: four low cycles per RAS pulse
  p_ras_width_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (!$past(ras_n, 1) && !$past(ras_n, 2) && !$past(ras_n, 3)
                      && !$past(ras_n, 4) && $past(ras_n, 5)));

  // R2: at least two high cycles before a fall
  p_ras_precharge_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> ($past(ras_n, 1) && $past(ras_n, 2)));

  // R3: CAS falls two cycles after RAS
  p_cas_delay_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> (!$past(ras_n, 1) && !$past(ras_n, 2) && $past(ras_n, 3)));

  // R3: CAS low for two cycles
  p_cas_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n) |-> (!$past(cas_n, 1) && !$past(cas_n, 2) && $past(cas_n, 3)));

  // R4: row held across the RAS fall
  p_row_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $stable(mem_addr));

  // R4: column set up before and held after the CAS fall
  p_col_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> $stable(mem_addr));
  p_col_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |=> $stable(mem_addr));

  // R5: WE leads CAS by three cycles on a write
  p_we_lead_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !we_n) |-> (!$past(we_n, 3) && $past(we_n, 4)));

  // R6: done accompanies the CAS rise
  p_done_on_cas_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n) |-> done);

  // R6: done is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: busy is low in the done cycle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind dram_page_seq dram_page_seq_chk #(.ADDR_PINS(ADDR_PINS)) u_chk (.*);

// File: tb/test_dram_page_seq.sv
module test_dram_page_seq;
  localparam int PINS = 11;
  localparam int NIB  = 4;
  localparam int AW   = 2 * PINS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req = 1'b0;
  logic            req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [NIB-1:0]  req_wnib = '0;
  logic            big_mem = 1'b0;
  logic            refresh_go = 1'b0;
  logic [NIB-1:0]  dq_in = '0;
  logic            ras_n, cas_n, we_n, dq_oe, done, busy;
  logic [PINS-1:0] mem_addr;
  logic [NIB-1:0]  dq_out, rd_nib;

  int n_chk = 0;
  int n_bad = 0;

  // chained-request parameters
  logic           nx_write;
  logic [AW-1:0]  nx_addr;
  logic [NIB-1:0] nx_nib;
  logic           nx_big;

  always #2 clk = ~clk;

  dram_page_seq i_dram_page_seq (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_addr(req_addr),
    .req_wnib(req_wnib), .big_mem(big_mem), .refresh_go(refresh_go), .dq_in(dq_in),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mem_addr(mem_addr), .dq_out(dq_out),
    .dq_oe(dq_oe), .rd_nib(rd_nib), .done(done), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_row(input logic [AW-1:0] a, input bit big);
    return big ? int'(a[AW-1:PINS]) : int'(a[2*PINS-3:PINS-1]);
  endfunction

  function automatic int exp_col(input logic [AW-1:0] a, input bit big);
    return big ? int'(a[PINS-1:0]) : int'(a[PINS-2:0]);
  endfunction

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [NIB-1:0] nib, input bit big);
    @(negedge clk);
    req = 1'b1; req_write = wr; req_addr = a; req_wnib = nib; big_mem = big;
    @(posedge clk);
  endtask

  // call right after the accepting edge; returns at the done cycle's falling edge
  task automatic observe(input string tg, input bit wr, input logic [AW-1:0] a,
                         input logic [NIB-1:0] nib, input bit big, input logic [NIB-1:0] rdval,
                         input bit poke, input bit chain);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 0) req = 1'b0;
      chk($sformatf("R2 %s ras_n k=%0d", tg, k), int'(ras_n), (k >= 1 && k <= 4) ? 0 : 1);
      chk($sformatf("R3 %s cas_n k=%0d", tg, k), int'(cas_n), (k == 3 || k == 4) ? 0 : 1);
      chk($sformatf("R5 %s we_n k=%0d", tg, k), int'(we_n), (wr && k <= 4) ? 0 : 1);
      chk($sformatf("R5 %s dq_oe k=%0d", tg, k), int'(dq_oe), (wr && k <= 4) ? 1 : 0);
      chk($sformatf("R5 %s dq_out k=%0d", tg, k), int'(dq_out), (wr && k <= 4) ? int'(nib) : 0);
      chk($sformatf("R4 %s %s mem_addr k=%0d", tg, big ? "R7" : "R8", k), int'(mem_addr),
          (k <= 1) ? exp_row(a, big) : (k <= 4) ? exp_col(a, big) : 0);
      if (!big) chk($sformatf("R8 %s a10 k=%0d", tg, k), int'(mem_addr[PINS-1]), 0);
      chk($sformatf("R10 %s busy k=%0d", tg, k), int'(busy), (k <= 4) ? 1 : 0);
      chk($sformatf("R6 %s done k=%0d", tg, k), int'(done), (k == 5) ? 1 : 0);
      if (!wr && k == 5) chk($sformatf("R6 %s rd_nib", tg), int'(rd_nib), int'(rdval));
      dq_in = (k == 4) ? rdval : ~rdval;
      if (poke && k == 1) begin
        req = 1'b1; req_write = ~wr; req_addr = ~a; refresh_go = 1'b1;
      end
      if (poke && k == 2) begin
        req = 1'b0; refresh_go = 1'b0;
      end
      if (chain && k == 5) begin
        req = 1'b1; req_write = nx_write; req_addr = nx_addr; req_wnib = nx_nib; big_mem = nx_big;
      end
    end
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk($sformatf("R10 %s idle ras_n j=%0d", tg, j), int'(ras_n), 1);
        chk($sformatf("R10 %s idle busy j=%0d", tg, j), int'(busy), 0);
        chk($sformatf("R10 %s idle mem_addr j=%0d", tg, j), int'(mem_addr), 0);
      end
    end
  endtask

  initial begin
    logic [AW-1:0]  a;
    logic [NIB-1:0] nib, rv;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ras_n", int'(ras_n), 1);
    chk("R1 cas_n", int'(cas_n), 1);
    chk("R1 we_n", int'(we_n), 1);
    chk("R1 dq_oe", int'(dq_oe), 0);
    chk("R1 dq_out", int'(dq_out), 0);
    chk("R1 mem_addr", int'(mem_addr), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 rd_nib", int'(rd_nib), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 busy after release", int'(busy), 0);
    chk("R1 ras_n after release", int'(ras_n), 1);

    // R7 / R8 sweep over sizes, directions and address patterns
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 16; i++) begin
        for (int w = 1; w >= 0; w--) begin
          if (i == 0)      a = '0;
          else if (i == 1) a = '1;
          else             a = AW'(i * 32'h0019_660D + 32'h3C6E_F35F);
          nib = NIB'(i * 5 + s * 3 + w);
          rv  = NIB'(i * 7 + 3 + s);
          issue(w[0], a, nib, s[0]);
          observe(s[0] ? "R7 sweep" : "R8 sweep", w[0], a, nib, s[0], rv, 1'b0, 1'b0);
        end
      end
    end

    // R10: requests and refresh raised mid-access are ignored
    issue(1'b0, 22'h2A5C3F, 4'h0, 1'b1);
    observe("R10 poke", 1'b0, 22'h2A5C3F, 4'h0, 1'b1, 4'h9, 1'b1, 1'b0);

    // R12: request during the done cycle is taken back to back
    nx_write = 1'b0; nx_addr = 22'h15A3C6; nx_nib = 4'h0; nx_big = 1'b0;
    issue(1'b1, 22'h3FF001, 4'hC, 1'b1);
    observe("R12 first", 1'b1, 22'h3FF001, 4'hC, 1'b1, 4'h0, 1'b0, 1'b1);
    @(posedge clk);
    observe("R12 second", 1'b0, 22'h15A3C6, 4'h0, 1'b0, 4'h6, 1'b0, 1'b0);

    // R9 / R11: refresh burst wins over a simultaneous request
    @(negedge clk);
    req = 1'b1; req_write = 1'b1; req_addr = 22'h0F0F0F; req_wnib = 4'hA; big_mem = 1'b1;
    refresh_go = 1'b1;
    @(posedge clk);
    for (int j = 0; j < 48; j++) begin
      @(negedge clk);
      if (j == 0) begin req = 1'b0; refresh_go = 1'b0; end
      chk($sformatf("R9 ras_n j=%0d", j), int'(ras_n), ((j % 6) >= 1 && (j % 6) <= 4) ? 0 : 1);
      chk($sformatf("R9 cas_n j=%0d", j), int'(cas_n), 1);
      chk($sformatf("R11 we_n j=%0d", j), int'(we_n), 1);
      chk($sformatf("R11 dq_oe j=%0d", j), int'(dq_oe), 0);
      chk($sformatf("R9 mem_addr j=%0d", j), int'(mem_addr), ((j % 6) <= 4) ? j / 6 : 0);
      chk($sformatf("R9 busy j=%0d", j), int'(busy), (j < 47) ? 1 : 0);
      chk($sformatf("R9 done j=%0d", j), int'(done), (j == 47) ? 1 : 0);
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk($sformatf("R11 dropped request ras_n j=%0d", j), int'(ras_n), 1);
      chk($sformatf("R11 dropped request busy j=%0d", j), int'(busy), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule